// File: doc/BRIEF.md
# Bus Error Capture Register

This block keeps a diagnostic record of the protocol errors that a CAN controller's bit engine detects. The engine reports each error as a one-cycle strobe on one of seven error-kind lines, together with the bit position inside the current frame. The block keeps two records. The first record holds the kind or kinds of the first error seen since the last clear, along with its bit position. The second record is a sticky mask of every error kind seen since that clear. When the first record fills, the block sends a one-cycle event to the interrupt logic.

Software reaches the block through one 32-bit register, with a write port and a read view that is always valid. A protection key must be written before any command is accepted. After that, commands can clear the records and switch capture on or off. The unlocked state lasts until the block's reset.

The record layout is as follows. Error kinds map to index 0 to 6 in the order overload, acknowledge, bit-0, bit-1, stuff, CRC and form. The first record occupies bits 6:0, the sticky mask bits 14:8 and the bit position bits 23:16. Bit 31 reads as the capture enable.

Top module: `err_cap_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears everything: `rd_data` becomes 0, `err_event` becomes 0 and the key lock is re-armed. This holds both at start-up and in the middle of operation.
- R2: Until the key has been written, any write other than the key has no effect: `rd_data` stays unchanged and capture stays off.
- R3: A write of exactly 0x21302899 unlocks the register until the next reset. The key write is not itself a command: it changes neither the enable nor the records, whether the block is locked or already unlocked.
- R4: Once unlocked, a write sets the capture enable to bit 31 of the written word, so a write of 0 disables capture. Bits 29:24 and 15, 7 and 30 of `rd_data` always read 0. Bit 31 reads as the current enable.
- R5: Once unlocked, a write with bit 30 set clears the first record, the sticky mask and the bit position. If bit 31 is also set in that word, capture is enabled in the same write.
- R6: While capture is enabled and the first record is zero, a non-zero `err_strobe` has two effects. It copies every strobe bit of that cycle into `rd_data[6:0]`, and it copies `err_bit_pos` into `rd_data[23:16]`. The index order is 0 overload, 1 acknowledge, 2 bit-0, 3 bit-1, 4 stuff, 5 CRC, 6 form.
- R7: Every accepted strobe ORs into the sticky mask at `rd_data[14:8]`, in the same index order. Once the first record is non-zero, later strobes change neither the first record nor the bit position.
- R8: `err_event` goes high for exactly one cycle, in the cycle after the strobe that fills the first record. Strobes that only add to the sticky mask give no event.
- R9: While capture is disabled, strobes are ignored and the captured content is kept.
- R10: When an accepted command write and a strobe arrive in the same cycle, the command wins and that cycle's strobe is dropped.
- R11: A strobe or write accepted at a clock edge is visible on `rd_data` right after that edge. No extra latency applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write word: key or command |
| rd_data | output | 32 | Current register view |
| err_strobe | input | 7 | One-cycle error-kind strobes, index 0..6 |
| err_bit_pos | input | 8 | Bit position in frame, sampled with the strobes |
| err_event | output | 1 | One-cycle pulse when the first record fills |

## Verification
The assertions do not assume that the strobes are one-hot. Several kinds may fire together and still count as one first error. The assertions also do not assume that writes and strobes are kept apart. They do take for granted that `err_bit_pos` has meaning only in cycles with a strobe, and that every input is sampled only at the rising edge. The stimulus drives all inputs half a period away from that edge and keeps each for exactly one edge. It includes multi-hot strobes and writes that coincide with strobes, so the priority and simultaneous-kind cases are covered.

// File: rtl/err_cap_pkg.sv
package err_cap_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_KINDS = 7;
    localparam int POS_W     = 8;

    localparam logic [REG_W-1:0] UNLOCK_KEY = 32'h2130_2899;

    localparam int FIRST_LSB = 0;
    localparam int ALL_LSB   = 8;
    localparam int POS_LSB   = 16;
    localparam int CLR_BIT   = 30;
    localparam int EN_BIT    = 31;

    typedef enum logic [2:0] {
        KIND_OVERLOAD = 3'd0,
        KIND_ACK      = 3'd1,
        KIND_BIT0     = 3'd2,
        KIND_BIT1     = 3'd3,
        KIND_STUFF    = 3'd4,
        KIND_CRC      = 3'd5,
        KIND_FORM     = 3'd6
    } err_kind_e;

    typedef logic [NUM_KINDS-1:0] err_vec_t;

    typedef struct packed {
        logic clear;
        logic enable;
    } cmd_t;

    typedef struct packed {
        err_vec_t         first;
        err_vec_t         all;
        logic [POS_W-1:0] pos;
    } rec_t;

    function automatic cmd_t decode_cmd(input logic [REG_W-1:0] w);
        cmd_t c;
        c.clear  = w[CLR_BIT];
        c.enable = w[EN_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_view(input rec_t r, input logic en);
        logic [REG_W-1:0] v;
        v = '0;
        v[FIRST_LSB +: NUM_KINDS] = r.first;
        v[ALL_LSB   +: NUM_KINDS] = r.all;
        v[POS_LSB   +: POS_W]     = r.pos;
        v[EN_BIT]                 = en;
        return v;
    endfunction

endpackage

// File: rtl/err_cap_keygate.sv
module err_cap_keygate
    import err_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             unlocked,
    output logic             cmd_valid,
    output cmd_t             cmd
);

    logic is_key;
    assign is_key = (wr_data == UNLOCK_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else if (wr_en && is_key) begin
            unlocked <= 1'b1;
        end
    end

    assign cmd_valid = wr_en && unlocked && !is_key;
    assign cmd       = decode_cmd(wr_data);

    // once open, the gate stays open until reset
    assert_unlock_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        unlocked |=> unlocked);

endmodule

// File: rtl/err_cap_record.sv
module err_cap_record
    import err_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  cmd_t             cmd,
    input  err_vec_t         strobe,
    input  logic [POS_W-1:0] bit_pos,
    output rec_t             rec_q,
    output logic             en_q,
    output logic             first_hit
);

    logic accept;
    assign accept    = !cmd_valid && en_q && (strobe != '0);
    assign first_hit = accept && (rec_q.first == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
            en_q  <= 1'b0;
        end else if (cmd_valid) begin
            en_q <= cmd.enable;
            if (cmd.clear) begin
                rec_q <= '0;
            end
        end else if (accept) begin
            rec_q.all <= rec_q.all | strobe;
            if (rec_q.first == '0) begin
                rec_q.first <= strobe;
                rec_q.pos   <= bit_pos;
            end
        end
    end

    assert_first_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rec_q.first != '0 && !(cmd_valid && cmd.clear))
        |=> (rec_q.first == $past(rec_q.first) && rec_q.pos == $past(rec_q.pos)));

    assert_all_grows_R7: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd.clear) |=> ((rec_q.all & $past(rec_q.all)) == $past(rec_q.all)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !cmd_valid) |=> $stable(rec_q));

    assert_cmd_priority_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd.clear) |=> (rec_q == $past(rec_q)));

    assert_first_in_all_R6: assert property (@(posedge clk) disable iff (rst)
        ((rec_q.all & rec_q.first) == rec_q.first));

endmodule

// File: rtl/err_cap_event.sv
module err_cap_event (
    input  logic clk,
    input  logic rst,
    input  logic first_hit,
    output logic err_event
);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_event <= 1'b0;
        end else begin
            err_event <= first_hit;
        end
    end

    assert_event_single_R8: assert property (@(posedge clk) disable iff (rst)
        err_event |=> !err_event);

endmodule

// File: rtl/err_cap_reg.sv
module err_cap_reg
    import err_cap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic [NUM_KINDS-1:0] err_strobe,
    input  logic [POS_W-1:0]     err_bit_pos,
    output logic                 err_event
);

    logic unlocked;
    logic cmd_valid;
    cmd_t cmd;
    rec_t rec_q;
    logic en_q;
    logic first_hit;

    err_cap_keygate u_gate (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .unlocked  (unlocked),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    err_cap_record u_rec (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .strobe    (err_strobe),
        .bit_pos   (err_bit_pos),
        .rec_q     (rec_q),
        .en_q      (en_q),
        .first_hit (first_hit)
    );

    err_cap_event u_evt (
        .clk       (clk),
        .rst       (rst),
        .first_hit (first_hit),
        .err_event (err_event)
    );

    assign rd_data = pack_view(rec_q, en_q);

    // while locked and idle, nothing can switch capture on
    assert_locked_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !en_q) |=> !en_q);

    // the event marks the edge where the first record went from empty to filled
    assert_event_first_R8: assert property (@(posedge clk) disable iff (rst)
        err_event |-> (rd_data[FIRST_LSB +: NUM_KINDS] != '0
                       && $past(rd_data[FIRST_LSB +: NUM_KINDS]) == '0));

    assert_zero_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_data[CLR_BIT] == 1'b0 && rd_data[29:24] == '0
         && rd_data[15] == 1'b0 && rd_data[7] == 1'b0));

endmodule

// File: tb/err_cap_reg_bench.sv
module err_cap_reg_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [6:0]  err_strobe = '0;
    logic [7:0]  err_bit_pos = '0;
    logic        err_event;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    err_cap_reg u_err_cap_reg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .err_strobe  (err_strobe),
        .err_bit_pos (err_bit_pos),
        .err_event   (err_event)
    );

    // {req[3:0], wr, wdata[31:0], strobe[6:0], pos[7:0], exp_rd[31:0], exp_ev}
    localparam int NV = 20;
    localparam logic [84:0] VECS [NV] = '{
        {4'd2,  1'b1, 32'h8000_0000, 7'h00, 8'h00, 32'h0000_0000, 1'b0}, // R2 enable while locked
        {4'd2,  1'b1, 32'h4000_0000, 7'h00, 8'h00, 32'h0000_0000, 1'b0}, // R2 clear while locked
        {4'd9,  1'b0, 32'h0000_0000, 7'h01, 8'h05, 32'h0000_0000, 1'b0}, // R9 strobe while off
        {4'd3,  1'b1, 32'h2130_2899, 7'h00, 8'h00, 32'h0000_0000, 1'b0}, // R3 key, no command
        {4'd5,  1'b1, 32'h4000_0000, 7'h00, 8'h00, 32'h0000_0000, 1'b0}, // R5 clear
        {4'd4,  1'b1, 32'h8000_0000, 7'h00, 8'h00, 32'h8000_0000, 1'b0}, // R4 enable
        {4'd6,  1'b0, 32'h0000_0000, 7'h02, 8'h2A, 32'h802A_0202, 1'b1}, // R6 R8 R11 ack first
        {4'd7,  1'b0, 32'h0000_0000, 7'h10, 8'h33, 32'h802A_1202, 1'b0}, // R7 stuff adds
        {4'd7,  1'b0, 32'h0000_0000, 7'h60, 8'h7F, 32'h802A_7202, 1'b0}, // R7 crc+form add
        {4'd8,  1'b0, 32'h0000_0000, 7'h00, 8'h00, 32'h802A_7202, 1'b0}, // R8 idle
        {4'd4,  1'b1, 32'h0000_0000, 7'h00, 8'h00, 32'h002A_7202, 1'b0}, // R4 write 0 disables
        {4'd9,  1'b0, 32'h0000_0000, 7'h01, 8'h44, 32'h002A_7202, 1'b0}, // R9 ignored, kept
        {4'd5,  1'b1, 32'hC000_0000, 7'h00, 8'h00, 32'h8000_0000, 1'b0}, // R5 clear+enable
        {4'd6,  1'b0, 32'h0000_0000, 7'h41, 8'hFF, 32'h80FF_4141, 1'b1}, // R6 multi-kind
        {4'd10, 1'b1, 32'h4000_0000, 7'h08, 8'h10, 32'h0000_0000, 1'b0}, // R10 clear beats strobe
        {4'd10, 1'b1, 32'h8000_0000, 7'h04, 8'h10, 32'h8000_0000, 1'b0}, // R10 enable drops strobe
        {4'd6,  1'b0, 32'h0000_0000, 7'h08, 8'h00, 32'h8000_0808, 1'b1}, // R6 bit-1 at pos 0
        {4'd3,  1'b1, 32'h2130_2899, 7'h00, 8'h00, 32'h8000_0808, 1'b0}, // R3 key when open
        {4'd4,  1'b1, 32'hBFFF_FFFF, 7'h00, 8'h00, 32'h8000_0808, 1'b0}, // R4 other bits ignored
        {4'd5,  1'b1, 32'h7FFF_FFFF, 7'h00, 8'h00, 32'h0000_0000, 1'b0}  // R5 clear, disable
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // called at a falling edge: applies inputs over one rising edge, returns at the next falling edge
    task automatic step(input logic w, input logic [31:0] d,
                        input logic [6:0] s, input logic [7:0] p);
        wr_en = w; wr_data = d; err_strobe = s; err_bit_pos = p;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; err_strobe = '0; err_bit_pos = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(1, "rd_data after reset", rd_data, 32'h0);
        check(1, "event after reset", {31'b0, err_event}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [84:0] v;
            v = VECS[i];
            wr_en = v[80]; wr_data = v[79:48]; err_strobe = v[47:41]; err_bit_pos = v[40:33];
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0; err_strobe = '0; err_bit_pos = '0;
            check(int'(v[84:81]), $sformatf("vector %0d rd_data", i), rd_data, v[32:1]);
            check(int'(v[84:81]), $sformatf("vector %0d event", i),
                  {31'b0, err_event}, {31'b0, v[0]});
        end

        // R1 reset in the middle of operation, then R3 lock re-armed
        step(1'b1, 32'h2130_2899, 7'h00, 8'h00);
        step(1'b1, 32'h8000_0000, 7'h00, 8'h00);
        step(1'b0, 32'h0, 7'h20, 8'h09);
        check(6, "capture before mid reset", rd_data, 32'h8009_2020);
        do_reset();
        check(1, "rd_data after mid reset", rd_data, 32'h0);
        step(1'b1, 32'h8000_0000, 7'h00, 8'h00);
        check(3, "enable ignored after reset relock", rd_data, 32'h0);

        // R8 event once, then none for a later strobe
        step(1'b1, 32'h2130_2899, 7'h00, 8'h00);
        step(1'b1, 32'h8000_0000, 7'h00, 8'h00);
        step(1'b0, 32'h0, 7'h20, 8'h11);
        check(8, "event on first capture", {31'b0, err_event}, 32'h1);
        step(1'b0, 32'h0, 7'h01, 8'h22);
        check(8, "no event on later error", {31'b0, err_event}, 32'h0);
        check(7, "later error only in sticky mask", rd_data, 32'h8011_2120);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule